// File: doc/BRIEF.md
# I2C Bus Event Decoder

A listen-only observer for a two-wire I2C bus. It samples the clock and data lines with the 50 MHz system clock, cleans each one with a short glitch filter, and turns the bus activity into a stream of discrete events. Start, stop and repeated start conditions are recognised. Each data bit is read while the clock is high and is committed on the following clock fall. Every byte is reported together with the state of its acknowledge bit.

Incomplete activity is reported too. If a byte is cut off by a stop or by a repeated start, it comes out as a short-byte event that carries the bits collected so far. A start that is followed by a stop with no data in between comes out as an empty-transaction event. Events leave through a single-entry valid/ready register. When the consumer stalls, the event already in the register is kept, and every later event that cannot be stored is counted in a saturating drop counter. The block never drives the bus.

Top module: `i2c_event_decoder`

## Requirements
- R1: A level on SCL or SDA that lasts only one clock cycle has no effect on any event.
- R2: A level held for two or more consecutive clock cycles is accepted. A two-cycle low pulse on SDA while SCL is high therefore gives a start event followed by an empty-transaction event.
- R3: SDA falling while SCL is high on an idle bus gives event kind 0 (start), with data 0, and opens a transaction.
- R4: Data bits are taken MSB first. The value is sampled at the SCL rise and committed at the SCL fall. At the fall of the ninth clock, the decoder emits kind 1 (acknowledged) if the ninth bit is low and kind 2 (not acknowledged) if it is high. The byte is in `evt_data_o`.
- R5: A stop or start that arrives inside an open transaction after 1 to 8 committed bits first emits kind 3 (short byte). Its data holds the committed bits right-aligned with the upper bits zero. The stop or repeated-start event follows on the next cycle.
- R6: A start inside an open transaction gives kind 4 (repeated start), with data 0.
- R7: SDA rising while SCL is high closes an open transaction. If no bit was committed since the opening start, the event is kind 5 (empty transaction); otherwise it is kind 6 (stop). Data is 0.
- R8: A stop condition while no transaction is open, and SCL edges outside a transaction, produce no event.
- R9: An event appears on `evt_valid_o` five clock edges after the input change that completes it: two synchronizer flops, one filter-history flop, the filtered-level flop, and the output register.
- R10: While `evt_valid_o` is high and `evt_ready_i` is low, the event outputs hold steady. Each new event in that state is discarded and increments `drop_cnt_o`, which saturates at its maximum.
- R11: After reset, `evt_valid_o` is 0 and `drop_cnt_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, 50 MHz |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Raw bus clock line |
| sda_i | input | 1 | Raw bus data line |
| evt_ready_i | input | 1 | Consumer accepts the current event |
| evt_valid_o | output | 1 | Event register holds an event |
| evt_kind_o | output | 3 | Event kind code (0..6, see R3 to R7) |
| evt_data_o | output | DATA_W | Byte or partial-byte value |
| drop_cnt_o | output | DROP_W | Saturating count of discarded events |

## Verification
A condition event is due exactly five clock edges after the edge on SDA that forms it. A byte or short-byte event is due five edges after the SCL fall or the condition that ends it. When an event is split in two, the second part follows one cycle after the first. The bench changes its inputs just after a rising edge and reads the outputs at the falling edge. It compares each accepted event against a queue of expected events that it fills from the bus sequence it drives. A dedicated probe checks that `evt_valid_o` is still low at the fourth edge and goes high at the fifth. Glitch, idle-stop and stall scenarios then confirm that no extra event is produced, and that the drop count and the held event match.

// File: rtl/i2c_mon_pkg.sv
`timescale 1ns/1ps
package i2c_mon_pkg;
  typedef enum logic [2:0] {
    EV_START   = 3'd0,
    EV_ACK     = 3'd1,
    EV_NAK     = 3'd2,
    EV_SHORT   = 3'd3,
    EV_RESTART = 3'd4,
    EV_EMPTY   = 3'd5,
    EV_STOP    = 3'd6
  } ev_kind_e;
endpackage

// File: rtl/i2c_glitch_filter.sv
`timescale 1ns/1ps
module i2c_glitch_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic line_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [FILT_LEN-2:0]    hist_q;
  logic [FILT_LEN-1:0]    window;
  logic                   sync_out;

  assign sync_out = sync_q[SYNC_STAGES-1];
  assign window   = {hist_q, sync_out};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
  end

  generate
    if (FILT_LEN == 2) begin : g_hist_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) hist_q <= '1;
        else         hist_q <= sync_out;
      end
    end else begin : g_hist_shift
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) hist_q <= '1;
        else         hist_q <= {hist_q[FILT_LEN-3:0], sync_out};
      end
    end
  endgenerate

  // level moves only when the whole window agrees
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          line_o <= 1'b1;
    else if (&window)     line_o <= 1'b1;
    else if (~|window)    line_o <= 1'b0;
  end

  // R1: a filtered change must follow a synchronized level that was already there
  a_r1_settled_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(line_o) |-> $past(sync_out) == line_o);
endmodule

// File: rtl/i2c_bit_engine.sv
`timescale 1ns/1ps
module i2c_bit_engine
  import i2c_mon_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              push_o,
  output ev_kind_e          kind_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DATA_W);

  logic              scl_q, sda_q;
  logic              in_txn_q, any_bits_q, pend_q, samp_q;
  logic [CNT_W-1:0]  bit_cnt_q;
  logic [DATA_W-1:0] shreg_q;
  logic              def_valid_q;
  ev_kind_e          def_kind_q;

  logic scl_rise, scl_fall, cond_start, cond_stop;

  assign scl_rise   = scl_i & ~scl_q;
  assign scl_fall   = ~scl_i & scl_q;
  assign cond_start = scl_i & scl_q & sda_q & ~sda_i;
  assign cond_stop  = scl_i & scl_q & ~sda_q & sda_i;

  always_comb begin
    push_o = 1'b0;
    kind_o = EV_START;
    data_o = '0;
    if (def_valid_q) begin
      push_o = 1'b1;
      kind_o = def_kind_q;
    end else if (cond_start) begin
      push_o = 1'b1;
      if (!in_txn_q) begin
        kind_o = EV_START;
      end else if (bit_cnt_q != '0) begin
        kind_o = EV_SHORT;
        data_o = shreg_q;
      end else begin
        kind_o = EV_RESTART;
      end
    end else if (cond_stop && in_txn_q) begin
      push_o = 1'b1;
      if (bit_cnt_q != '0) begin
        kind_o = EV_SHORT;
        data_o = shreg_q;
      end else begin
        kind_o = any_bits_q ? EV_STOP : EV_EMPTY;
      end
    end else if (scl_fall && pend_q && in_txn_q && bit_cnt_q == FULL_CNT) begin
      push_o = 1'b1;
      kind_o = samp_q ? EV_NAK : EV_ACK;
      data_o = shreg_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q       <= 1'b1;
      sda_q       <= 1'b1;
      in_txn_q    <= 1'b0;
      any_bits_q  <= 1'b0;
      pend_q      <= 1'b0;
      samp_q      <= 1'b0;
      bit_cnt_q   <= '0;
      shreg_q     <= '0;
      def_valid_q <= 1'b0;
      def_kind_q  <= EV_STOP;
    end else begin
      scl_q       <= scl_i;
      sda_q       <= sda_i;
      def_valid_q <= 1'b0;
      if (cond_start) begin
        pend_q    <= 1'b0;
        in_txn_q  <= 1'b1;
        bit_cnt_q <= '0;
        shreg_q   <= '0;
        if (!in_txn_q) begin
          any_bits_q <= 1'b0;
        end else if (bit_cnt_q != '0) begin
          def_valid_q <= 1'b1;
          def_kind_q  <= EV_RESTART;
        end
      end else if (cond_stop) begin
        pend_q <= 1'b0;
        if (in_txn_q) begin
          in_txn_q  <= 1'b0;
          bit_cnt_q <= '0;
          shreg_q   <= '0;
          if (bit_cnt_q != '0) begin
            def_valid_q <= 1'b1;
            def_kind_q  <= EV_STOP;
          end
        end
      end else begin
        if (scl_rise && in_txn_q) begin
          pend_q <= 1'b1;
          samp_q <= sda_i;
        end
        if (scl_fall && pend_q) begin
          pend_q     <= 1'b0;
          any_bits_q <= 1'b1;
          if (bit_cnt_q == FULL_CNT) begin
            bit_cnt_q <= '0;
            shreg_q   <= '0;
          end else begin
            bit_cnt_q <= bit_cnt_q + 1'b1;
            shreg_q   <= {shreg_q[DATA_W-2:0], samp_q};
          end
        end
      end
    end
  end

  a_r4_bitcnt_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_cnt_q <= FULL_CNT);
  a_r3_start_from_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_o && kind_o == EV_START) |=> in_txn_q);
  // R5: a short byte is always followed at once by its closing condition
  a_r5_short_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_o && kind_o == EV_SHORT) |=> (push_o && (kind_o == EV_STOP || kind_o == EV_RESTART)));
  a_r8_no_event_idle_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_txn_q |-> (bit_cnt_q == '0 && !pend_q));
endmodule

// File: rtl/i2c_event_slot.sv
`timescale 1ns/1ps
module i2c_event_slot
  import i2c_mon_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DROP_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  ev_kind_e          kind_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              ready_i,
  output logic              valid_o,
  output ev_kind_e          kind_o,
  output logic [DATA_W-1:0] data_o,
  output logic [DROP_W-1:0] drop_cnt_o
);
  localparam logic [DROP_W-1:0] DROP_MAX = '1;

  logic stalled;
  assign stalled = valid_o & ~ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o    <= 1'b0;
      kind_o     <= EV_START;
      data_o     <= '0;
      drop_cnt_o <= '0;
    end else if (push_i) begin
      if (stalled) begin
        if (drop_cnt_o != DROP_MAX) drop_cnt_o <= drop_cnt_o + 1'b1;
      end else begin
        valid_o <= 1'b1;
        kind_o  <= kind_i;
        data_o  <= data_i;
      end
    end else if (valid_o && ready_i) begin
      valid_o <= 1'b0;
    end
  end

  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i) |=> (valid_o && $stable(kind_o) && $stable(data_o)));
  a_r10_drop_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && valid_o && !ready_i && drop_cnt_o != DROP_MAX) |=> drop_cnt_o == $past(drop_cnt_o) + 1'b1);
  a_r10_drop_monotonic: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!push_i || !valid_o || ready_i) |=> $stable(drop_cnt_o));
endmodule

// File: rtl/i2c_event_decoder.sv
`timescale 1ns/1ps
module i2c_event_decoder
  import i2c_mon_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int DROP_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              evt_ready_i,
  output logic              evt_valid_o,
  output logic [2:0]        evt_kind_o,
  output logic [DATA_W-1:0] evt_data_o,
  output logic [DROP_W-1:0] drop_cnt_o
);
  logic              scl_f, sda_f;
  logic              push;
  ev_kind_e          push_kind, slot_kind;
  logic [DATA_W-1:0] push_data;

  i2c_glitch_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_scl_filt (
    .clk_i(clk_i), .rst_ni(rst_ni), .line_i(scl_i), .line_o(scl_f));

  i2c_glitch_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_sda_filt (
    .clk_i(clk_i), .rst_ni(rst_ni), .line_i(sda_i), .line_o(sda_f));

  i2c_bit_engine #(.DATA_W(DATA_W)) u_engine (
    .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl_f), .sda_i(sda_f),
    .push_o(push), .kind_o(push_kind), .data_o(push_data));

  i2c_event_slot #(.DATA_W(DATA_W), .DROP_W(DROP_W)) u_slot (
    .clk_i(clk_i), .rst_ni(rst_ni), .push_i(push), .kind_i(push_kind),
    .data_i(push_data), .ready_i(evt_ready_i), .valid_o(evt_valid_o),
    .kind_o(slot_kind), .data_o(evt_data_o), .drop_cnt_o(drop_cnt_o));

  assign evt_kind_o = slot_kind;

  a_r11_kind_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_valid_o |-> evt_kind_o <= 3'd6);
endmodule

// File: tb/tb_i2c_event_decoder.sv
`timescale 1ns/1ps
module tb_i2c_event_decoder;
  localparam int H = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1, sda = 1'b1, rdy = 1'b1;
  logic       evt_valid;
  logic [2:0] evt_kind;
  logic [7:0] evt_data;
  logic [7:0] drop_cnt;

  int checks = 0, failures = 0;
  int   q_kind[$];
  int   q_data[$];
  string q_tag[$];

  always #10 clk = ~clk;

  i2c_event_decoder dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda), .evt_ready_i(rdy),
    .evt_valid_o(evt_valid), .evt_kind_o(evt_kind), .evt_data_o(evt_data),
    .drop_cnt_o(drop_cnt));

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic expect_ev(input int k, input int d, input string tag);
    q_kind.push_back(k); q_data.push_back(d); q_tag.push_back(tag);
  endtask

  // reference: every accepted event must be the next one predicted
  always @(negedge clk) begin
    if (rst_n && evt_valid && rdy) begin
      if (q_kind.size() == 0) begin
        chk(1'b0, "R8", "unexpected event kind", evt_kind, -1);
      end else begin
        int k, d;
        string t;
        k = q_kind.pop_front(); d = q_data.pop_front(); t = q_tag.pop_front();
        chk(evt_kind == k, t, "event kind", evt_kind, k);
        chk(evt_data == d, t, "event data", evt_data, d);
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic i2c_start;
    sda = 1'b0; step(H); scl = 1'b0; step(H);
  endtask
  task automatic i2c_bit(input logic b);
    sda = b; step(H); scl = 1'b1; step(H); scl = 1'b0; step(H);
  endtask
  task automatic i2c_byte(input logic [7:0] b, input logic ack);
    for (int i = 7; i >= 0; i--) i2c_bit(b[i]);
    i2c_bit(ack);
  endtask
  task automatic i2c_rstart;
    sda = 1'b1; step(H); scl = 1'b1; step(H); sda = 1'b0; step(H); scl = 1'b0; step(H);
  endtask
  task automatic i2c_stop;
    sda = 1'b0; step(H); scl = 1'b1; step(H); sda = 1'b1; step(H);
  endtask
  task automatic drained(input string tag);
    step(20);
    chk(q_kind.size() == 0, tag, "events still missing", q_kind.size(), 0);
    chk(evt_valid == 1'b0, tag, "valid idle", evt_valid, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "R9", "watchdog expired", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    step(3);
    chk(evt_valid == 1'b0, "R11", "valid in reset", evt_valid, 0);
    chk(drop_cnt == 8'd0, "R11", "drop count in reset", drop_cnt, 0);
    rst_n = 1'b1;
    step(4);
    chk(evt_valid == 1'b0, "R11", "valid after reset", evt_valid, 0);

    // R9: start latency probe, then R3/R4/R7 write
    expect_ev(0, 0, "R3");
    sda = 1'b0;
    repeat (5) @(negedge clk);
    chk(evt_valid == 1'b0, "R9", "valid at edge 4", evt_valid, 0);
    @(negedge clk);
    chk(evt_valid == 1'b1, "R9", "valid at edge 5", evt_valid, 1);
    step(H); scl = 1'b0; step(H);
    expect_ev(1, 8'hA0, "R4"); expect_ev(1, 8'h0B, "R4"); expect_ev(6, 0, "R7");
    i2c_byte(8'hA0, 1'b0); i2c_byte(8'h0B, 1'b0); i2c_stop;
    drained("R4");

    // R6: read with repeated start and NAK
    expect_ev(0, 0, "R3"); expect_ev(1, 8'hA0, "R4"); expect_ev(4, 0, "R6");
    expect_ev(1, 8'hA1, "R4"); expect_ev(2, 8'h08, "R4"); expect_ev(6, 0, "R7");
    i2c_start; i2c_byte(8'hA0, 1'b0); i2c_rstart; i2c_byte(8'hA1, 1'b0);
    i2c_byte(8'h08, 1'b1); i2c_stop;
    drained("R6");

    // R7: empty transaction
    expect_ev(0, 0, "R3"); expect_ev(5, 0, "R7");
    i2c_start; i2c_stop;
    drained("R7");

    // R5: three bits then stop
    expect_ev(0, 0, "R3"); expect_ev(3, 8'h05, "R5"); expect_ev(6, 0, "R5");
    i2c_start; i2c_bit(1); i2c_bit(0); i2c_bit(1); i2c_stop;
    drained("R5");

    // R5: five bits then repeated start
    expect_ev(0, 0, "R3"); expect_ev(3, 8'h19, "R5"); expect_ev(4, 0, "R6");
    expect_ev(1, 8'h55, "R4"); expect_ev(6, 0, "R7");
    i2c_start; i2c_bit(1); i2c_bit(1); i2c_bit(0); i2c_bit(0); i2c_bit(1);
    i2c_rstart; i2c_byte(8'h55, 1'b0); i2c_stop;
    drained("R5");

    // R5: eight bits without acknowledge
    expect_ev(0, 0, "R3"); expect_ev(3, 8'hC3, "R5"); expect_ev(6, 0, "R5");
    i2c_start;
    for (int i = 7; i >= 0; i--) i2c_bit(logic'((8'hC3 >> i) & 1));
    i2c_stop;
    drained("R5");

    // R1: single-cycle SDA glitch on idle bus
    sda = 1'b0; step(1); sda = 1'b1;
    drained("R1");

    // R1: single-cycle SCL glitch inside a byte
    expect_ev(0, 0, "R3"); expect_ev(1, 8'h3C, "R1"); expect_ev(6, 0, "R7");
    i2c_start;
    for (int i = 7; i >= 0; i--) begin
      sda = logic'((8'h3C >> i) & 1); step(H); scl = 1'b1; step(3);
      if (i == 2) begin scl = 1'b0; step(1); scl = 1'b1; step(H - 4); end
      else step(H - 3);
      scl = 1'b0; step(H);
    end
    i2c_bit(0); i2c_stop;
    drained("R1");

    // R2: two-cycle SDA low pulse while SCL high
    expect_ev(0, 0, "R2"); expect_ev(5, 0, "R2");
    sda = 1'b0; step(2); sda = 1'b1;
    drained("R2");

    // R8: stop with no open transaction, SCL toggles outside
    scl = 1'b0; step(H); sda = 1'b0; step(H); scl = 1'b1; step(H); sda = 1'b1;
    drained("R8");

    // R10: stall, hold first event, drop the rest
    rdy = 1'b0;
    expect_ev(0, 0, "R10");
    i2c_start; i2c_byte(8'h5A, 1'b0); i2c_stop;
    step(20);
    chk(evt_valid == 1'b1, "R10", "held valid", evt_valid, 1);
    chk(evt_kind == 3'd0, "R10", "held kind", evt_kind, 0);
    chk(drop_cnt == 8'd2, "R10", "drop count", drop_cnt, 2);
    rdy = 1'b1;
    drained("R10");
    chk(drop_cnt == 8'd2, "R10", "drop count kept", drop_cnt, 2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule